// File: doc/BRIEF.md
# Registered ROM with Programmable Initialization

A 2048-byte read-only store whose read data always passes through an edge-triggered output register, so a looked-up byte appears one rising clock edge after its address is applied. While the outputs hold one byte, the address may already move on to the next location, which suits pipelined microcoded sequencers. An active-low, level-sensitive initialize input loads a separately stored extra byte into the output register immediately, without a clock. This gives a start-up or jump-start word, a clear (all zeros) or a preset (all ones).

The output bus is modelled as a data vector plus one valid flag that stands in for a tri-state driver. A configuration byte selects how the active-low enable acts. In asynchronous style the enable gates the outputs at once. In synchronous style the enable is sampled on the rising clock edge. The array, the initialize byte and the configuration byte are loaded before operation through a write port that works only while a configuration flag is high.

Top module: `regrom_top`

## Requirements
- R1: On each rising edge of `clk` the byte stored at `addr` is captured, and `dout` shows it from that edge until the next one.
- R2: Changing `addr` between rising edges leaves `dout` unchanged until the next rising edge.
- R3: While `init_n` is low, the output register holds the stored initialize byte. It is loaded at once when `init_n` falls, with no clock needed, and it takes priority over capture at any rising edge that sees `init_n` low.
- R4: An initialize byte that has never been written is zero, so initialize acts as a clear. Writing 0xFF makes it a preset.
- R5: With bit 0 of the configuration byte at 0 (asynchronous style, the default), `dout_vld` equals the inverse of `en_n` with no clock involved.
- R6: With bit 0 of the configuration byte at 1 (synchronous style), `dout_vld` changes only on a rising edge, to the inverse of `en_n` sampled at that edge.
- R7: In synchronous style, after reset or after configuration mode, the outputs stay off until the first rising edge at which `en_n` is sampled low.
- R8: Writes take effect only while `cfg_mode` is high. Configuration address 0x000–0x7FF holds array bytes, 0x800 holds the initialize byte and 0x801 holds the configuration byte. A write with `cfg_mode` low changes nothing.
- R9: `dout` is zero whenever `dout_vld` is low.
- R10: A rising edge with `rst_n` low clears the output register, the initialize byte and the configuration byte, and sets the synchronous enable state to off. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge captures data and samples the enable |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | High while the store is being loaded |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration address (array, initialize byte, configuration byte) |
| cfg_wdata | input | 8 | Configuration write data |
| addr | input | 11 | Read address |
| en_n | input | 1 | Active-low output enable |
| init_n | input | 1 | Active-low level-sensitive initialize |
| dout | output | 8 | Registered output data, zero when not valid |
| dout_vld | output | 1 | Output-driven flag standing in for tri-state |

## Verification
A wrong array byte or a capture bug shows up at `dout` one rising edge after the affected address is applied. A register that follows the address between edges shows up within the same cycle. An initialize path that waits for the clock shows a stale byte right after `init_n` falls. A synchronous enable state with the wrong reset or lag shows `dout_vld` on or off one edge early or late, from the first edge after configuration mode.

// File: rtl/regrom_pkg.sv
package regrom_pkg;
    // Output-enable style held in bit 0 of the configuration byte
    typedef enum logic {
        OE_ASYNC = 1'b0,
        OE_SYNC  = 1'b1
    } oe_style_e;

    // Target of a configuration write
    typedef enum logic [1:0] {
        SEL_ARRAY,
        SEL_INIT,
        SEL_STYLE,
        SEL_NONE
    } cfg_sel_e;
endpackage

// File: rtl/regrom_store.sv
// regrom_store: byte array with combinational read, plus the initialize byte
// and the enable-style bit, all written through the configuration port.
// Assumes configuration writes happen only before normal operation.
module regrom_store
    import regrom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_we,
    input  logic [ADDR_W:0]   cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] init_word,
    output oe_style_e         style
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    cfg_sel_e          sel;
    logic              wr_ok;

    // Decode the configuration address into its target
    always_comb begin
        if (!cfg_addr[ADDR_W])
            sel = SEL_ARRAY;
        else if (cfg_addr[ADDR_W-1:0] == '0)
            sel = SEL_INIT;
        else if (cfg_addr[ADDR_W-1:0] == ADDR_W'(1))
            sel = SEL_STYLE;
        else
            sel = SEL_NONE;
    end

    assign wr_ok = cfg_mode && cfg_we;

    // Array write; contents survive reset
    always_ff @(posedge clk) begin
        if (wr_ok && sel == SEL_ARRAY)
            mem[cfg_addr[ADDR_W-1:0]] <= cfg_wdata;
    end

    // Initialize byte and style bit, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_word <= '0;
            style     <= OE_ASYNC;
        end else if (wr_ok && sel == SEL_INIT) begin
            init_word <= cfg_wdata;
        end else if (wr_ok && sel == SEL_STYLE) begin
            style     <= oe_style_e'(cfg_wdata[0]);
        end
    end

    // Asynchronous array read
    assign rd_data = mem[rd_addr];

    // R8: configuration state cannot move outside configuration mode
    p_cfg_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && $past(rst_n)) |=> ($stable(init_word) && $stable(style)));
endmodule

// File: rtl/regrom_outreg.sv
// regrom_outreg: output data register. A low init_n loads the initialize byte
// at once and holds it; otherwise the read data is captured at each rising edge.
// Assumes the initialize byte does not change while init_n is low.
module regrom_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic [DATA_W-1:0] init_word,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] q
);
    // Level-sensitive initialize load, then synchronous reset, then capture
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n)
            q <= init_word;
        else if (!rst_n)
            q <= '0;
        else
            q <= rd_data;
    end

    // R3: a low initialize level keeps the register on the initialize byte
    p_init_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_n && $stable(init_word)) |-> (q == init_word));
endmodule

// File: rtl/regrom_oectl.sv
// regrom_oectl: output-enable control. In asynchronous style the enable passes
// straight through; in synchronous style it is registered at each rising edge.
// The registered state is forced off during reset and configuration.
module regrom_oectl
    import regrom_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_mode,
    input  oe_style_e style,
    input  logic      en_n,
    output logic      out_on
);
    logic en_q;

    // Registered enable, starting in the off (set) state
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_mode)
            en_q <= 1'b1;
        else
            en_q <= en_n;
    end

    // Choose the enable path by style
    always_comb begin
        if (style == OE_SYNC)
            out_on = !en_q;
        else
            out_on = !en_n;
    end

    // R6: in synchronous style the outputs follow the enable one edge later
    p_sync_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (style == OE_SYNC && $past(rst_n) && !$past(cfg_mode))
        |-> (out_on == !$past(en_n)));

    // R7: the first edge after configuration leaves synchronous outputs off
    p_cfg_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode) && style == OE_SYNC) |-> !out_on);
endmodule

// File: rtl/regrom_top.sv
// regrom_top: registered ROM with a level-sensitive initialize and a
// configurable output enable. The output bus is data plus a valid flag;
// data reads as zero whenever the bus would be off.
module regrom_top
    import regrom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode,
    input  logic              cfg_we,
    input  logic [ADDR_W:0]   cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    input  logic              init_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] init_word;
    logic [DATA_W-1:0] q;
    oe_style_e         style;
    logic              out_on;

    regrom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(addr),
        .rd_data(rd_data), .init_word(init_word), .style(style)
    );

    regrom_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .init_word(init_word),
        .rd_data(rd_data), .q(q)
    );

    regrom_oectl u_oectl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .style(style),
        .en_n(en_n), .out_on(out_on)
    );

    // Blank the data while the bus is off
    assign dout     = out_on ? q : '0;
    assign dout_vld = out_on;

    // R9: an off bus never carries data
    p_off_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));
endmodule

// File: tb/regrom_top_test.sv
module regrom_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [10:0] addr = '0;
    logic        en_n = 1'b1;
    logic        init_n = 1'b1;
    logic [7:0]  dout;
    logic        dout_vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    regrom_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .addr(addr),
        .en_n(en_n), .init_n(init_n), .dout(dout), .dout_vld(dout_vld)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7 + (a >> 8)) & 255);
    endfunction

    // Compare {valid, data}
    task automatic chk(input string req, input logic v, input logic [7:0] d);
        checks++;
        if (dout_vld !== v || dout !== d) begin
            fails++;
            $display("FAIL %s: actual vld=%0b dout=%02h expected vld=%0b dout=%02h",
                     req, dout_vld, dout, v, d);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R10 reset off", 1'b0, 8'h00);
        en_n = 1'b0;
        #1 chk("R10 reset clears register, R5 async on", 1'b1, 8'h00);

        // Load the array
        @(negedge clk); cfg_mode = 1'b1;
        for (int a = 0; a < 2048; a++) wr(a, pat(a));
        @(negedge clk); cfg_mode = 1'b0;

        // R4 unwritten initialize byte clears
        addr = 11'd5;
        @(posedge clk); #2 chk("R1 read 5", 1'b1, pat(5));
        @(negedge clk); init_n = 1'b0;
        #1 chk("R4 clear", 1'b1, 8'h00);
        @(negedge clk); init_n = 1'b1;

        // R8 write outside configuration ignored
        wr(7, ~pat(7));
        wr(12'h801, 1);
        @(negedge clk); addr = 11'd7;
        @(posedge clk); #2 chk("R8 ignored write", 1'b1, pat(7));
        @(negedge clk); en_n = 1'b1;
        #1 chk("R8 style unchanged, R5 off at once", 1'b0, 8'h00);
        en_n = 1'b0;

        // R1/R2 sweep
        for (int a = 0; a < 2048; a++) begin
            @(negedge clk); addr = 11'(a);
            @(posedge clk); #2 chk("R1 capture", 1'b1, pat(a));
            addr = ~11'(a);
            #2 chk("R2 address move", 1'b1, pat(a));
        end

        // Initialize byte 0xA5
        @(negedge clk); cfg_mode = 1'b1;
        wr(12'h800, 8'hA5);
        @(negedge clk); cfg_mode = 1'b0; init_n = 1'b0; addr = 11'd3;
        #1 chk("R3 immediate load", 1'b1, 8'hA5);
        @(posedge clk); #2 chk("R3 priority at edge", 1'b1, 8'hA5);
        @(negedge clk); init_n = 1'b1;
        #1 chk("R3 hold until edge", 1'b1, 8'hA5);
        @(posedge clk); #2 chk("R1 after initialize", 1'b1, pat(3));

        // Initialize while disabled, then enable
        @(negedge clk); en_n = 1'b1; init_n = 1'b0;
        #1 chk("R9 blank while off", 1'b0, 8'h00);
        en_n = 1'b0;
        #1 chk("R5 enable shows init byte", 1'b1, 8'hA5);
        @(negedge clk); init_n = 1'b1;

        // Preset
        @(negedge clk); cfg_mode = 1'b1;
        wr(12'h800, 8'hFF);
        @(negedge clk); cfg_mode = 1'b0; init_n = 1'b0;
        #1 chk("R4 preset", 1'b1, 8'hFF);
        @(negedge clk); init_n = 1'b1;

        // Synchronous style
        @(negedge clk); cfg_mode = 1'b1;
        wr(12'h801, 1);
        @(negedge clk); cfg_mode = 1'b0; addr = 11'd11; en_n = 1'b0;
        #1 chk("R7 off after configuration", 1'b0, 8'h00);
        @(posedge clk); #2 chk("R7 on after first edge", 1'b1, pat(11));
        @(negedge clk); en_n = 1'b1;
        #1 chk("R6 no immediate off", 1'b1, pat(11));
        @(posedge clk); #2 chk("R6 off at edge", 1'b0, 8'h00);
        @(negedge clk); en_n = 1'b0; addr = 11'd100;
        #1 chk("R6 no immediate on", 1'b0, 8'h00);
        @(posedge clk); #2 chk("R6 on at edge", 1'b1, pat(100));
        for (int a = 1000; a < 1064; a++) begin
            @(negedge clk); addr = 11'(a);
            @(posedge clk); #2 chk("R1 sync capture", 1'b1, pat(a));
        end

        // Reset clears configuration, keeps array
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1 chk("R10 register cleared", 1'b1, 8'h00);
        en_n = 1'b1;
        #1 chk("R10 style back to async", 1'b0, 8'h00);
        en_n = 1'b0; init_n = 1'b0;
        #1 chk("R10 init byte cleared", 1'b1, 8'h00);
        @(negedge clk); init_n = 1'b1; addr = 11'd9;
        @(posedge clk); #2 chk("R10 array kept", 1'b1, pat(9));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule